// File: doc/BRIEF.md
# Abortable Serial Byte Transmitter

This block sends one asynchronous serial frame for each send request: a low start bit, eight data bits with the least significant bit first, and a high stop bit. Between frames the line rests high. Timing comes from a tick enable that pulses at eight times the bit rate, and every bit on the wire lasts exactly eight of those ticks.

The block is meant for a wire that several senders share. A drive-enable output is high for the whole time a frame is on the wire, so an external buffer can drive the shared line only while this sender owns it. An abort input lets the sender back off at once when another circuit reports a collision. It releases the line and drops the enable on the next clock. A busy output mirrors the enable so that upstream logic can hold new bytes back. A one-cycle done strobe marks each frame that finished without an abort.

Top module: `abortable_uart_tx`

## Requirements
- R1: After reset and whenever no frame is in progress, `txLine` is 1, `txEnable` is 0 and `busy` is 0.
- R2: When `sendReq` is 1 at a clock edge while idle and `abortTx` is 0, the block captures `dataIn`. From the next cycle `txEnable` is 1 and `txLine` is 0, which is the start bit.
- R3: A frame on `txLine` is the start bit (0), then `dataIn[0]` up to `dataIn[7]`, then the stop bit (1). Each bit holds for exactly 8 `tickEn` pulses counted from the start of the frame, and `txLine` changes only at a clock edge where `tickEn` is 1.
- R4: `txEnable` stays 1 from the first start-bit cycle until the clock edge that carries the 80th tick of the frame, and falls to 0 at that edge.
- R5: A `sendReq` pulse during a frame is ignored, and so is any change of `dataIn` after capture. The frame carries the captured byte, and no second frame follows.
- R6: When `abortTx` is 1 at a clock edge, `txLine` is 1 and `txEnable` is 0 from the next cycle, and the block is idle. An abort at the same edge as a `sendReq` while idle prevents the frame from starting.
- R7: `doneTx` is 1 for exactly one cycle, the first cycle with `txEnable` low after a frame that completed. It stays 0 for an aborted frame, including an abort that arrives at the same edge as the final tick.
- R8: `busy` equals `txEnable` at all times.
- R9: After an abort, the next send request starts a full frame with fresh bit timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sendReq | input | 1 | Request to send `dataIn`; taken only while idle |
| dataIn | input | 8 | Byte to send |
| tickEn | input | 1 | Tick enable at eight times the bit rate |
| abortTx | input | 1 | Abandon the current frame and release the line |
| txLine | output | 1 | Serial output; rests high |
| txEnable | output | 1 | High while a frame is being driven |
| busy | output | 1 | Same as `txEnable`, for upstream flow control |
| doneTx | output | 1 | One-cycle strobe after a frame completes |

## Verification
The risky overlap is an abort that arrives at the same clock edge as the tick that ends the stop bit. At that edge the frame is finishing normally and being cancelled at once. The bench places `abortTx` on exactly the 80th tick of a frame. The line and enable must still return to idle on the next cycle, but `doneTx` must stay low, because the abort takes priority over completion. A second overlap is an abort together with a send request while idle. The bench judges it by checking that `txEnable` never rises and that no frame reaches its scoreboard.

// File: rtl/abtx_pkg.sv
package abtx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } txState_t;

  // strobes from the control to the datapath, at most one active per cycle
  typedef struct packed {
    logic loadByte;     // capture byte, drive start bit
    logic shiftOut;     // put next data bit on the line
    logic driveStop;    // drive the stop bit
    logic releaseLine;  // return the line to rest
  } txStrobe_t;

endpackage

// File: rtl/abtx_ctrl.sv
module abtx_ctrl
  import abtx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 8
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      sendReq,
  input  logic      tickEn,
  input  logic      abortTx,
  output txStrobe_t strobe,
  output logic      txEnable,
  output logic      doneTx
);

  localparam int TICK_W = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
  localparam int BIT_W  = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(OVERSAMPLE - 1);
  localparam logic [BIT_W-1:0]  BIT_LAST  = BIT_W'(DATA_W - 1);

  txState_t          state, nextState;
  logic [TICK_W-1:0] tickCnt;
  logic [BIT_W-1:0]  bitCnt;
  logic              bitEnd;
  logic              doneNext;

  assign bitEnd = (state != ST_IDLE) && tickEn && (tickCnt == TICK_LAST);

  always_comb begin
    strobe    = '0;
    nextState = state;
    doneNext  = 1'b0;
    if (abortTx) begin
      strobe.releaseLine = 1'b1;
      nextState          = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (sendReq) begin
            strobe.loadByte = 1'b1;
            nextState       = ST_START;
          end
        end
        ST_START: begin
          if (bitEnd) begin
            strobe.shiftOut = 1'b1;
            nextState       = ST_DATA;
          end
        end
        ST_DATA: begin
          if (bitEnd) begin
            if (bitCnt == BIT_LAST) begin
              strobe.driveStop = 1'b1;
              nextState        = ST_STOP;
            end else begin
              strobe.shiftOut = 1'b1;
            end
          end
        end
        ST_STOP: begin
          if (bitEnd) begin
            strobe.releaseLine = 1'b1;
            nextState          = ST_IDLE;
            doneNext           = 1'b1;
          end
        end
        default: nextState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitCnt  <= '0;
      doneTx  <= 1'b0;
    end else begin
      state  <= nextState;
      doneTx <= doneNext;

      if (abortTx || state == ST_IDLE) begin
        tickCnt <= '0;
      end else if (tickEn) begin
        tickCnt <= (tickCnt == TICK_LAST) ? '0 : tickCnt + TICK_W'(1);
      end

      if (state != ST_DATA || abortTx) begin
        bitCnt <= '0;
      end else if (bitEnd) begin
        bitCnt <= bitCnt + BIT_W'(1);
      end
    end
  end

  assign txEnable = (state != ST_IDLE);

endmodule

// File: rtl/abtx_datapath.sv
module abtx_datapath
  import abtx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  txStrobe_t         strobe,
  input  logic [DATA_W-1:0] dataIn,
  output logic              txLine
);

  logic [DATA_W-1:0] shiftReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg <= '0;
      txLine   <= 1'b1;
    end else if (strobe.releaseLine) begin
      txLine <= 1'b1;
    end else if (strobe.loadByte) begin
      shiftReg <= dataIn;
      txLine   <= 1'b0;
    end else if (strobe.shiftOut) begin
      txLine   <= shiftReg[0];
      shiftReg <= {1'b0, shiftReg[DATA_W-1:1]};
    end else if (strobe.driveStop) begin
      txLine <= 1'b1;
    end
  end

endmodule

// File: rtl/abortable_uart_tx.sv
module abortable_uart_tx
  import abtx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sendReq,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              tickEn,
  input  logic              abortTx,
  output logic              txLine,
  output logic              txEnable,
  output logic              busy,
  output logic              doneTx
);

  txStrobe_t strobe;

  abtx_ctrl #(
    .DATA_W    (DATA_W),
    .OVERSAMPLE(OVERSAMPLE)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .sendReq (sendReq),
    .tickEn  (tickEn),
    .abortTx (abortTx),
    .strobe  (strobe),
    .txEnable(txEnable),
    .doneTx  (doneTx)
  );

  abtx_datapath #(
    .DATA_W(DATA_W)
  ) u_dp (
    .clk   (clk),
    .rst   (rst),
    .strobe(strobe),
    .dataIn(dataIn),
    .txLine(txLine)
  );

  assign busy = txEnable;

endmodule

// File: rtl/abtx_checker.sv
module abtx_checker (
  input logic clk,
  input logic rst,
  input logic sendReq,
  input logic tickEn,
  input logic abortTx,
  input logic txLine,
  input logic txEnable,
  input logic doneTx
);

  // R1
  idle_line_high_chk: assert property (@(posedge clk) disable iff (rst)
    !txEnable |-> txLine);

  // R2
  start_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (!txEnable && sendReq && !abortTx) |=> (txEnable && !txLine));

  // R3
  line_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (txEnable && !tickEn && !abortTx) |=> $stable(txLine));

  // R4
  enable_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (txEnable && !tickEn && !abortTx) |=> txEnable);

  // R6
  abort_release_chk: assert property (@(posedge clk) disable iff (rst)
    abortTx |=> (!txEnable && txLine && !doneTx));

  // R7
  done_after_frame_chk: assert property (@(posedge clk) disable iff (rst)
    doneTx |-> (!txEnable && $past(txEnable)));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    doneTx |=> !doneTx);

endmodule

bind abortable_uart_tx abtx_checker u_chk (
  .clk     (clk),
  .rst     (rst),
  .sendReq (sendReq),
  .tickEn  (tickEn),
  .abortTx (abortTx),
  .txLine  (txLine),
  .txEnable(txEnable),
  .doneTx  (doneTx)
);

// File: tb/tb_abortable_uart_tx.sv
`timescale 1ns/100ps
module tb_abortable_uart_tx;

  typedef struct {
    logic [7:0] data;
    int         abortAt;   // tick index of abort, -1 for a full frame
  } item_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sendReq = 1'b0;
  logic [7:0] dataIn = 8'h00;
  logic       tickEn = 1'b0;
  logic       abortMon = 1'b0;
  logic       abortDrv = 1'b0;
  logic       abortTx;
  logic       txLine, txEnable, busy, doneTx;

  int errors = 0;
  int checks = 0;
  item_t expQ[$];

  assign abortTx = abortMon | abortDrv;

  always #2.5 clk = ~clk;

  abortable_uart_tx dut (
    .clk(clk), .rst(rst), .sendReq(sendReq), .dataIn(dataIn),
    .tickEn(tickEn), .abortTx(abortTx), .txLine(txLine),
    .txEnable(txEnable), .busy(busy), .doneTx(doneTx)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: drives the tick and timed aborts, and compares each frame
  item_t      cur;
  logic       active = 1'b0;
  logic       prevEn = 1'b0;
  logic       abortPending = 1'b0;
  logic [9:0] seenBits;
  logic [9:0] seenMask;
  int         bitIdx, tickIn, totalTicks;
  int         tickPh = 0;

  always @(negedge clk) begin
    if (rst) begin
      prevEn = 1'b0; tickEn = 1'b0; abortMon = 1'b0; active = 1'b0;
    end else begin
      if (abortPending) begin
        check("R6", "line after abort", txLine, 1);
        check("R6", "enable after abort", txEnable, 0);
        abortPending = 1'b0;
      end
      if (txEnable && !prevEn) begin
        check("R8", "busy at frame start", busy, 1);
        check("R2", "start bit level", txLine, 0);
        if (expQ.size() == 0) begin
          check("R5", "unexpected frame started", 1, 0);
          cur.data = 8'h00; cur.abortAt = -1;
        end else begin
          cur = expQ.pop_front();
        end
        active = 1'b1; bitIdx = 0; tickIn = 0; totalTicks = 0;
        seenBits = '0; seenMask = '0;
      end
      if (active && txEnable && tickIn == 4 && bitIdx < 10) begin
        seenBits[bitIdx] = txLine;
        seenMask[bitIdx] = 1'b1;
      end
      if (!txEnable && prevEn) begin
        logic [9:0] expBits;
        expBits = {1'b1, cur.data, 1'b0};
        check("R8", "busy at frame end", busy, 0);
        if (cur.abortAt < 0) begin
          check("R7", "done after full frame", doneTx, 1);
          check("R4", "ticks in frame", totalTicks, 80);
          check("R3", "frame bits", seenBits, expBits);
        end else begin
          check("R7", "no done after abort", doneTx, 0);
          check("R6", "bits before abort", seenBits & seenMask, expBits & seenMask);
        end
        active = 1'b0;
      end else if (doneTx) begin
        check("R7", "done outside frame end", 1, 0);
      end
      tickPh = (tickPh + 1) % 4;
      tickEn = (tickPh == 0);
      abortMon = 1'b0;
      if (active && txEnable && tickEn) begin
        if (totalTicks == cur.abortAt) begin
          abortMon = 1'b1;
          abortPending = 1'b1;
        end
        totalTicks++;
        tickIn++;
        if (tickIn == 8) begin
          tickIn = 0;
          bitIdx++;
        end
      end
      prevEn = txEnable;
    end
  end

  // driver: pushes the expected frame, then requests it
  task automatic sendFrame(input logic [7:0] d, input int abortAt, input bit pokeMid);
    item_t it;
    it.data = d; it.abortAt = abortAt;
    expQ.push_back(it);
    @(negedge clk); sendReq = 1'b1; dataIn = d;
    @(negedge clk); sendReq = 1'b0; dataIn = ~d;
    if (pokeMid) begin
      repeat (100) @(negedge clk);
      sendReq = 1'b1; dataIn = 8'h5A;
      @(negedge clk); sendReq = 1'b0;
    end
    while (txEnable) @(negedge clk);
    repeat (6) @(negedge clk);
    if (pokeMid) check("R5", "no frame after ignored request", txEnable, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "line at reset", txLine, 1);
    check("R1", "enable at reset", txEnable, 0);
    check("R8", "busy at reset", busy, 0);
    check("R7", "done at reset", doneTx, 0);

    sendFrame(8'hA5, -1, 0);          // R3 alternating pattern
    sendFrame(8'h00, -1, 0);          // R3 all zeros
    sendFrame(8'hFF, -1, 0);          // R3 all ones
    sendFrame(8'h3C, -1, 1);          // R5 request mid-frame
    sendFrame(8'h96, 37, 0);          // R6 abort inside a data bit
    sendFrame(8'h81, 0, 0);           // R6 abort on the first tick
    sendFrame(8'hC3, 79, 0);          // R7 abort on the final tick
    sendFrame(8'h5E, -1, 0);          // R9 full frame after aborts

    // R6 abort together with a request while idle
    @(negedge clk); sendReq = 1'b1; abortDrv = 1'b1; dataIn = 8'h77;
    @(negedge clk); sendReq = 1'b0; abortDrv = 1'b0;
    check("R6", "no start when abort meets request", txEnable, 0);
    repeat (4) @(negedge clk);
    check("R6", "line still idle", txLine, 1);

    sendFrame(8'h01, -1, 0);          // R9 single low bit set
    check("R3", "all frames consumed", expQ.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule